// File: doc/BRIEF.md
# Down-Counting Event Timer

This block is a bus-programmed countdown timer with one interrupt line. Software writes a 64-bit reload value as two 32-bit words, picks one-shot or repeating operation and 32-bit or 64-bit counting width in a control word, and then sets the run bit. The counter steps down by one on every clock where the tick input is high. When it reaches zero it raises a sticky event flag. Software acknowledges that flag by writing a one to an acknowledge bit. The interrupt line is the event flag gated by an enable bit.

The count can be read live as two words. It can also be read through a snapshot pair: reading the snapshot low word copies the whole 64-bit count, so the later read of the snapshot high word matches that low word. The count runs downward, so the elapsed tick count is its bitwise inverse. A 32-bit repeating count loaded with all ones reads as a free-running up-counter once the low word is inverted.

The bus uses 32-bit word addressing. A read strobe returns data one cycle later. A write strobe takes effect at the clock edge on which it is sampled.

Top module: `evt_timer`

## Requirements
- R1: After reset every stored value is zero: reload value, control bits, interrupt enable, event flag, count and snapshot. The `irq` and `bus_rdata` outputs are 0.
- R2: Word 0 holds the low half of the reload value and word 1 holds the high half. Both are writable and read back exactly what was written.
- R3: Word 4 is control. Bit 0 selects repeating mode, bit 1 is run and bit 16 selects 64-bit width. All other bits read back as 0.
- R4: A write to word 4 that sets bit 1 while run is clear loads the count from the reload value at that same edge. If the write's bit 16 is clear, the high half of the count is forced to zero. A write that sets bit 1 while run is already set does not reload.
- R5: While run is set and the count is nonzero, each clock with `tick_en` high lowers the full 64-bit count by one, borrowing across the halves. With `tick_en` low or run clear, the count holds.
- R6: In one-shot mode a tick at count 1 takes the count to 0 and raises the event flag. The count then stays at 0 and no further event occurs until the timer is started again.
- R7: In repeating mode a tick at count 1 raises the event flag and reloads the count from the reload value, so events come every N ticks for a reload value of N.
- R8: The event flag is set on the edge where the count expires. It stays set until word 5 is written with bit 3 high. If an expiry falls on the same edge as that acknowledge write, the flag stays set.
- R9: Word 5 reads as follows: bit 0 is interrupt enable, bit 1 is the event flag, bit 2 is the event flag AND enable, and bit 3 always reads 0. Writing bits 1 and 2 has no effect.
- R10: `irq` is high exactly when the event flag and the interrupt enable are both set.
- R11: Words 2 and 3 return the low and high halves of the live count.
- R12: Reading word 6 captures the full 64-bit count into the snapshot and returns its low half. Word 7 returns the captured high half and does not change when the count moves on.
- R13: `bus_rdata` carries the addressed word in the cycle after a read strobe. It is 0 in any cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-step enable, one step per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | ADDR_W (3) | Word index of the register accessed |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Active-high interrupt, event flag gated by enable |

## Verification
The countdown is tried with several reload values, and each one separates a different fault:
- A short one-shot reload of 5 catches off-by-one errors in when the count expires.
- A reload of 4 in repeating mode shows that the period is exactly the reload value.
- A 64-bit reload of 0x1_0000_0003 moves the count through a borrow from the high half. It also lets the snapshot high word be compared with the live high word after they have diverged.
- A reload of 1 in repeating mode makes every tick an expiry, which forces an acknowledge write to land on an expiry edge.
- An all-ones 32-bit reload checks the inverted free-running reading.

Stretches with `tick_en` held low, and a second run write to a timer that is already running, tell holding apart from stray decrements and stray reloads.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   typedef enum logic [2:0] {
      REG_LOAD_LO = 3'd0,
      REG_LOAD_HI = 3'd1,
      REG_VAL_LO  = 3'd2,
      REG_VAL_HI  = 3'd3,
      REG_CTRL    = 3'd4,
      REG_IRQ     = 3'd5,
      REG_SHD_LO  = 3'd6,
      REG_SHD_HI  = 3'd7
   } reg_sel_e;

   localparam int CTL_PERIODIC = 0;
   localparam int CTL_RUN      = 1;
   localparam int CTL_WIDE     = 16;

   localparam int IRQ_ENABLE   = 0;
   localparam int IRQ_RAW      = 1;
   localparam int IRQ_MASKED   = 2;
   localparam int IRQ_ACK      = 3;

   localparam int SEL_W        = 3;

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
   import evt_timer_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  reg_sel_e            sel,
   input  logic [DATA_W-1:0]   wdata,
   output logic [2*DATA_W-1:0] load,
   output logic                run,
   output logic                periodic,
   output logic                wide,
   output logic                irq_en,
   output logic                start,
   output logic                start_wide,
   output logic                ack
);

   localparam int HALVES = 2;

   logic [DATA_W-1:0] half_q [HALVES];
   logic              wr_ctrl;
   logic              wr_irq;

   assign wr_ctrl = wr_en && (sel == REG_CTRL);
   assign wr_irq  = wr_en && (sel == REG_IRQ);

   // one storage word per reload half
   for (genvar h = 0; h < HALVES; h++) begin : g_half
      localparam reg_sel_e HALF_SEL = (h == 0) ? REG_LOAD_LO : REG_LOAD_HI;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            half_q[h] <= '0;
         else if (wr_en && (sel == HALF_SEL))
            half_q[h] <= wdata;
      end
   end

   assign load = {half_q[1], half_q[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         periodic <= 1'b0;
         wide     <= 1'b0;
      end else if (wr_ctrl) begin
         run      <= wdata[CTL_RUN];
         periodic <= wdata[CTL_PERIODIC];
         wide     <= wdata[CTL_WIDE];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_en <= 1'b0;
      else if (wr_irq)
         irq_en <= wdata[IRQ_ENABLE];
   end

   // a start happens only on a clear-to-set transition of run
   assign start      = wr_ctrl && wdata[CTL_RUN] && !run;
   assign start_wide = wdata[CTL_WIDE];
   assign ack        = wr_irq && wdata[IRQ_ACK];

endmodule

// File: rtl/evt_timer_count.sv
module evt_timer_count #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_wide,
   input  logic [CNT_W-1:0] load,
   input  logic             run,
   input  logic             periodic,
   input  logic             wide,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             expire
);

   localparam int HALF_W = CNT_W / 2;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   function automatic logic [CNT_W-1:0] fit(input logic [CNT_W-1:0] v, input logic w);
      fit = w ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
   endfunction

   logic step;

   assign step   = run && tick && !start && (count != '0);
   assign expire = step && (count == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (start)
         count <= fit(load, start_wide);
      else if (expire)
         count <= periodic ? fit(load, wide) : '0;
      else if (step)
         count <= count - ONE;
   end

endmodule

// File: rtl/evt_timer_status.sv
module evt_timer_status (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic ack,
   input  logic irq_en,
   output logic raw,
   output logic irq
);

   // expiry wins over a coincident acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         raw <= 1'b0;
      else if (expire)
         raw <= 1'b1;
      else if (ack)
         raw <= 1'b0;
   end

   assign irq = raw && irq_en;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import evt_timer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_word,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   localparam int CNT_W = 2 * DATA_W;

   if (DATA_W != 32) begin : g_bad_data_w
      $error("evt_timer: DATA_W must be 32");
   end
   if (ADDR_W < SEL_W) begin : g_bad_addr_w
      $error("evt_timer: ADDR_W must cover eight words");
   end

   logic addr_ok;
   if (ADDR_W > SEL_W) begin : g_addr_wide
      assign addr_ok = ~|bus_word[ADDR_W-1:SEL_W];
   end else begin : g_addr_exact
      assign addr_ok = 1'b1;
   end

   reg_sel_e         sel;
   logic [CNT_W-1:0] load;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] shadow;
   logic             run, periodic, wide, irq_en;
   logic             start, start_wide, ack, expire, raw;
   logic [DATA_W-1:0] ctrl_word, irq_word;

   assign sel = reg_sel_e'(bus_word[SEL_W-1:0]);

   evt_timer_regs #(.DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bus_wr && addr_ok),
      .sel        (sel),
      .wdata      (bus_wdata),
      .load       (load),
      .run        (run),
      .periodic   (periodic),
      .wide       (wide),
      .irq_en     (irq_en),
      .start      (start),
      .start_wide (start_wide),
      .ack        (ack)
   );

   evt_timer_count #(.CNT_W(CNT_W)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_wide (start_wide),
      .load       (load),
      .run        (run),
      .periodic   (periodic),
      .wide       (wide),
      .tick       (tick_en),
      .count      (count),
      .expire     (expire)
   );

   evt_timer_status u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .expire (expire),
      .ack    (ack),
      .irq_en (irq_en),
      .raw    (raw),
      .irq    (irq)
   );

   always_comb begin
      ctrl_word               = '0;
      ctrl_word[CTL_PERIODIC] = periodic;
      ctrl_word[CTL_RUN]      = run;
      ctrl_word[CTL_WIDE]     = wide;
   end

   always_comb begin
      irq_word             = '0;
      irq_word[IRQ_ENABLE] = irq_en;
      irq_word[IRQ_RAW]    = raw;
      irq_word[IRQ_MASKED] = raw && irq_en;
   end

   // snapshot of the full count, taken on a low-half snapshot read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shadow <= '0;
      else if (bus_rd && addr_ok && (sel == REG_SHD_LO))
         shadow <= count;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_rd && addr_ok) begin
         unique case (sel)
            REG_LOAD_LO: bus_rdata <= load[DATA_W-1:0];
            REG_LOAD_HI: bus_rdata <= load[CNT_W-1:DATA_W];
            REG_VAL_LO:  bus_rdata <= count[DATA_W-1:0];
            REG_VAL_HI:  bus_rdata <= count[CNT_W-1:DATA_W];
            REG_CTRL:    bus_rdata <= ctrl_word;
            REG_IRQ:     bus_rdata <= irq_word;
            REG_SHD_LO:  bus_rdata <= count[DATA_W-1:0];
            REG_SHD_HI:  bus_rdata <= shadow[CNT_W-1:DATA_W];
            default:     bus_rdata <= '0;
         endcase
      end else
         bus_rdata <= '0;
   end

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
   parameter int CNT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             run,
   input logic             periodic,
   input logic             start,
   input logic             start_wide,
   input logic             ack,
   input logic             expire,
   input logic             raw,
   input logic             irq,
   input logic             irq_en,
   input logic [CNT_W-1:0] load,
   input logic [CNT_W-1:0] count
);

   localparam int HALF_W = CNT_W / 2;

   AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> count == ($past(start_wide) ? $past(load)
                                            : {{HALF_W{1'b0}}, $past(load[HALF_W-1:0])})); // R4

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      run && tick_en && !start && (count > CNT_W'(1)) |=> count == $past(count) - CNT_W'(1)); // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !start && !tick_en |=> $stable(count)); // R5

   AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      !periodic && !start && (count == '0) |=> count == '0); // R6

   AST_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> raw); // R8

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      raw && !ack |=> raw); // R8

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq); // R10

endmodule

bind evt_timer evt_timer_chk #(.CNT_W(2 * DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_en    (tick_en),
   .run        (run),
   .periodic   (periodic),
   .start      (start),
   .start_wide (start_wide),
   .ack        (ack),
   .expire     (expire),
   .raw        (raw),
   .irq        (irq),
   .irq_en     (irq_en),
   .load       (load),
   .count      (count)
);

// File: tb/evt_timer_test.sv
`timescale 1ns/1ps
module evt_timer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [2:0]  bus_word = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   evt_timer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_word  (bus_word),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // behavioural reference
   logic [63:0] m_load, m_cnt, m_shd, nc;
   logic        m_run, m_per, m_wide, m_ie, m_raw, fire;
   logic [31:0] m_rdata, r;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_load = '0; m_cnt = '0; m_shd = '0;
         m_run = 0; m_per = 0; m_wide = 0; m_ie = 0; m_raw = 0;
         m_rdata = '0;
      end else begin
         r = '0;
         if (bus_rd) begin
            case (bus_word)
               3'd0: r = m_load[31:0];
               3'd1: r = m_load[63:32];
               3'd2: r = m_cnt[31:0];
               3'd3: r = m_cnt[63:32];
               3'd4: r = {15'd0, m_wide, 14'd0, m_run, m_per};
               3'd5: r = {29'd0, m_raw & m_ie, m_raw, m_ie};
               3'd6: begin r = m_cnt[31:0]; m_shd = m_cnt; end
               default: r = m_shd[63:32];
            endcase
         end
         m_rdata = r;
         fire = 0;
         nc = m_cnt;
         if (bus_wr && bus_word == 3'd4 && bus_wdata[1] && !m_run)
            nc = bus_wdata[16] ? m_load : {32'd0, m_load[31:0]};
         else if (m_run && tick_en && m_cnt != 0) begin
            if (m_cnt == 64'd1) begin
               fire = 1;
               nc = m_per ? (m_wide ? m_load : {32'd0, m_load[31:0]}) : 64'd0;
            end else
               nc = m_cnt - 64'd1;
         end
         if (fire) m_raw = 1;
         else if (bus_wr && bus_word == 3'd5 && bus_wdata[3]) m_raw = 0;
         if (bus_wr) begin
            case (bus_word)
               3'd0: m_load[31:0]  = bus_wdata;
               3'd1: m_load[63:32] = bus_wdata;
               3'd4: begin m_run = bus_wdata[1]; m_per = bus_wdata[0]; m_wide = bus_wdata[16]; end
               3'd5: m_ie = bus_wdata[0];
               default: ;
            endcase
         end
         m_cnt = nc;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // every-clock comparison with the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R10 irq vs model", {31'd0, irq}, {31'd0, m_raw & m_ie});
         chk("R13 rdata vs model", bus_rdata, m_rdata);
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_word = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_rd = 1'b1; bus_word = a;
      @(negedge clk);
      bus_rd = 1'b0;
      v = bus_rdata;
   endtask

   task automatic wait_irq(output int n);
      n = 0;
      while (!irq && n < 100) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq after reset", {31'd0, irq}, 32'd0);
      chk("R1 rdata after reset", bus_rdata, 32'd0);
      rd(3'd4, v); chk("R1 control reset", v, 32'd0);
      rd(3'd5, v); chk("R1 interrupt word reset", v, 32'd0);
      rd(3'd2, v); chk("R1 count reset", v, 32'd0);

      // reload halves
      wr(3'd0, 32'd5);
      wr(3'd1, 32'd7);
      rd(3'd0, v); chk("R2 reload low", v, 32'd5);
      rd(3'd1, v); chk("R2 reload high", v, 32'd7);

      // one-shot, narrow width
      wr(3'd5, 32'h1);
      tick_en = 1'b1;
      wr(3'd4, 32'hFFFE_FFFE);
      wait_irq(n);
      chk("R6 one-shot delay of 5", n, 32'd5);
      rd(3'd4, v); chk("R3 control readback", v, 32'h2);
      rd(3'd3, v); chk("R4 narrow start clears high count", v, 32'd0);
      repeat (10) @(negedge clk);
      rd(3'd2, v); chk("R6 count parked at zero", v, 32'd0);
      rd(3'd5, v); chk("R9 interrupt word pending", v, 32'h7);

      // status bit writes ignored, then acknowledge
      wr(3'd5, 32'h6);
      rd(3'd5, v); chk("R9 status bits not writable", v, 32'h2);
      chk("R10 irq low with enable clear", {31'd0, irq}, 32'd0);
      wr(3'd5, 32'h9);
      rd(3'd5, v); chk("R8 acknowledge clears flag, R9 ack reads 0", v, 32'h1);
      repeat (10) @(negedge clk);
      chk("R6 no second one-shot event", {31'd0, irq}, 32'd0);

      // wide count, holding, borrow and snapshot
      tick_en = 1'b0;
      wr(3'd4, 32'h0);
      wr(3'd0, 32'd3);
      wr(3'd1, 32'd1);
      wr(3'd4, 32'h0001_0002);
      rd(3'd3, v); chk("R4 wide start high half, R11", v, 32'd1);
      rd(3'd2, v); chk("R4 wide start low half, R11", v, 32'd3);
      repeat (5) @(negedge clk);
      rd(3'd2, v); chk("R5 hold without tick", v, 32'd3);
      tick_en = 1'b1; repeat (3) @(negedge clk); tick_en = 1'b0;
      rd(3'd6, v); chk("R12 snapshot low", v, 32'd0);
      tick_en = 1'b1; repeat (2) @(negedge clk); tick_en = 1'b0;
      rd(3'd7, v); chk("R12 snapshot high kept", v, 32'd1);
      rd(3'd3, v); chk("R11 live high after borrow", v, 32'd0);
      rd(3'd2, v); chk("R5 borrow across halves", v, 32'hFFFF_FFFE);
      wr(3'd4, 32'h0001_0002);
      rd(3'd2, v); chk("R4 no reload while running", v, 32'hFFFF_FFFE);

      // repeating mode
      wr(3'd4, 32'h0);
      wr(3'd0, 32'd4);
      wr(3'd1, 32'd0);
      wr(3'd5, 32'h9);
      tick_en = 1'b1;
      wr(3'd4, 32'h3);
      wait_irq(n);
      tick_en = 1'b0;
      chk("R7 first period", n, 32'd4);
      rd(3'd2, v); chk("R7 reload after expiry", v, 32'd4);
      wr(3'd5, 32'h9);
      chk("R8 flag cleared", {31'd0, irq}, 32'd0);
      tick_en = 1'b1;
      wait_irq(n);
      chk("R7 second period", n, 32'd4);

      // acknowledge landing on an expiry
      tick_en = 1'b0;
      wr(3'd4, 32'h0);
      wr(3'd0, 32'd1);
      wr(3'd4, 32'h3);
      tick_en = 1'b1;
      repeat (2) @(negedge clk);
      wr(3'd5, 32'h9);
      rd(3'd5, v); chk("R8 expiry beats acknowledge", v, 32'h7);

      // free-running inverted reading
      tick_en = 1'b0;
      wr(3'd4, 32'h0);
      wr(3'd0, 32'hFFFF_FFFF);
      wr(3'd4, 32'h3);
      tick_en = 1'b1; repeat (10) @(negedge clk); tick_en = 1'b0;
      rd(3'd2, v); chk("R5 inverted count equals ticks", ~v, 32'd10);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule